// File: doc/BRIEF.md
# Command Mailbox Between Host Register Port and Acquisition Processor

This block is the device-side command mailbox that an external host uses to pass requests to an embedded acquisition processor. The host reaches it through a byte-wide register port with four register slots. A single shared buffer holds both the outgoing command frame and the returned response frame. An auto-incrementing pointer is the only way the host can address that buffer.

A host transaction has a fixed order. The host zeroes the pointer and streams the command frame into the data slot: a command byte, a message-id byte, then the payload. It then raises the request flag, and the processor sees this as `proc_req`. The processor reads the command through its own random-access port, writes a response frame into the same buffer (two header bytes followed by the payload), and pulses `proc_done`. The host polls the status slot until the flag drops, zeroes the pointer again and reads the response back.

Neither port has back-pressure. Every host strobe and every processor write is accepted in the cycle it is presented. The register port is a plain strobe interface and not a valid/ready stream, so no stalls are possible. If a host finds the flag still set from an earlier request, it can clear the flag itself before sending a new command.

Top module: `cmd_mailbox`

## Requirements
- R1: While `rst_n` is low and after it is released, the pointer is 0, the request flag is 0, `host_rdata` is 0 and every buffer byte is 0.
- R2: A host write to slot 0 loads the pointer from the low 6 bits of `host_wdata`, and the upper bits are ignored. A host read of slot 0 returns the pointer zero-extended to 8 bits.
- R3: A host write to slot 1 stores `host_wdata` at the current pointer and then advances the pointer by one.
- R4: A host read of slot 1 puts the byte at the current pointer on `host_rdata` one cycle after the strobe, and advances the pointer by one. `host_rdata` changes only on an accepted read and holds otherwise.
- R5: The pointer wraps from 63 to 0 on both data writes and data reads.
- R6: A host write to slot 2 copies bit 0 of `host_wdata` into the request flag only when bit 1 (load enable) of that same write is 1. With bit 1 at 0, the write leaves the flag unchanged.
- R7: A one-cycle `proc_done` pulse clears the flag. If a host clear and `proc_done` fall in the same cycle, the flag ends clear. If a host set and `proc_done` fall in the same cycle, the flag ends set.
- R8: A host read of slot 2 returns the flag in bit 0, with bits 7..1 at 0. The read does not change the pointer or the flag.
- R9: `proc_rdata` shows the buffer byte at `proc_addr` combinationally, and `proc_we` writes `proc_wdata` there. When the host data write and `proc_we` hit the same byte in one cycle, the host value is kept.
- R10: When `host_wr` and `host_rd` are both high, only the write takes effect. Slot 3 reads as 0, and writes to slot 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Register slot: 0 pointer, 1 data, 2 status, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 8 | Registered read byte, valid the cycle after a read strobe |
| proc_req | output | 1 | Request flag: a command is waiting for the processor |
| proc_addr | input | 6 | Processor buffer address |
| proc_wdata | input | 8 | Processor write byte |
| proc_we | input | 1 | Processor write enable |
| proc_rdata | output | 8 | Buffer byte at `proc_addr` |
| proc_done | input | 1 | One-cycle pulse: response is ready |

## Verification
The bench targets the same-cycle races, where a wrong design behaves in a visible way. A wrong flag merge would let `proc_done` override a fresh host set and drop a command silently. A wrong buffer priority would let the processor's byte overwrite the host's byte. An off-by-one pointer update would return the response shifted by one byte. The bench also covers the pointer wrap at 63, which a design without the wrap would lose by running off the buffer. It covers status reads, which must not advance the pointer, and simultaneous read and write strobes, which must not disturb `host_rdata`. A load-enable bit that is ignored would show up as the flag rising on a status write that has bit 1 clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SLOT_PTR  = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_STAT = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  // status slot bit positions; the processor handshake depends on them
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_LOAD_BIT = 1;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          p_we,
  input  logic [AW-1:0] p_addr,
  input  logic [DW-1:0] p_wdata,
  output logic [DW-1:0] p_rdata
);
  logic [DW-1:0] cells [DEPTH];

  // processor write first, host write last: host wins on a shared byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      if (p_we) cells[p_addr] <= p_wdata;
      if (h_we) cells[h_addr] <= h_wdata;
    end
  end

  assign h_rdata = cells[h_addr];
  assign p_rdata = cells[p_addr];
endmodule

// File: rtl/mbox_ptr.sv
module mbox_ptr #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/mbox_reqflag.sv
module mbox_reqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic host_load,
  input  logic host_val,
  input  logic done,
  output logic flag
);
  // a gated host write outranks done; a host clear and done agree anyway
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (host_load) flag <= host_val;
    else if (done)      flag <= 1'b0;
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic          proc_req,
  input  logic [AW-1:0] proc_addr,
  input  logic [DW-1:0] proc_wdata,
  input  logic          proc_we,
  output logic [DW-1:0] proc_rdata,
  input  logic          proc_done
);
  import mbox_pkg::*;

  slot_e         slot;
  logic          wr_ptr, wr_dat, wr_stat, rd_ok, rd_dat;
  logic [AW-1:0] ptr;
  logic [DW-1:0] buf_at_ptr;
  logic [DW-1:0] ptr_ext, stat_word, rd_next;

  assign slot    = slot_e'(host_addr);
  assign wr_ptr  = host_wr && (slot == SLOT_PTR);
  assign wr_dat  = host_wr && (slot == SLOT_DATA);
  assign wr_stat = host_wr && (slot == SLOT_STAT) && host_wdata[STAT_LOAD_BIT];
  assign rd_ok   = host_rd && !host_wr;
  assign rd_dat  = rd_ok && (slot == SLOT_DATA);

  mbox_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_ptr),
    .load_val (host_wdata[AW-1:0]),
    .step     (wr_dat || rd_dat),
    .ptr      (ptr)
  );

  mbox_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_we    (wr_dat),
    .h_addr  (ptr),
    .h_wdata (host_wdata),
    .h_rdata (buf_at_ptr),
    .p_we    (proc_we),
    .p_addr  (proc_addr),
    .p_wdata (proc_wdata),
    .p_rdata (proc_rdata)
  );

  mbox_reqflag flag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_load (wr_stat),
    .host_val  (host_wdata[STAT_FLAG_BIT]),
    .done      (proc_done),
    .flag      (proc_req)
  );

  always_comb begin
    ptr_ext = '0;
    ptr_ext[AW-1:0] = ptr;
    stat_word = '0;
    stat_word[STAT_FLAG_BIT] = proc_req;
    unique case (slot)
      SLOT_PTR:  rd_next = ptr_ext;
      SLOT_DATA: rd_next = buf_at_ptr;
      SLOT_STAT: rd_next = stat_word;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     host_rdata <= '0;
    else if (rd_ok) host_rdata <= rd_next;
  end
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic          proc_req,
  input logic          proc_done
);
  logic stat_load, stat_set;
  assign stat_load = host_wr && (host_addr == 2'd2) && host_wdata[1];
  assign stat_set  = stat_load && host_wdata[0];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd || host_wr) |=> $stable(host_rdata)); // R4

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set |=> proc_req); // R6

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_load && !proc_done) |=> $stable(proc_req)); // R6

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_done && !stat_set) |=> !proc_req); // R7

  AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_addr == 2'd2) |=>
      (host_rdata[DW-1:1] == '0 && host_rdata[0] == $past(proc_req))); // R8
endmodule

bind cmd_mailbox mbox_checker #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .proc_req   (proc_req),
  .proc_done  (proc_done)
);

// File: tb/cmd_mailbox_tb_top.sv
`timescale 1ns/1ps
module cmd_mailbox_tb_top;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [DW-1:0] host_rdata;
  logic          proc_req;
  logic [AW-1:0] proc_addr = '0;
  logic [DW-1:0] proc_wdata = '0;
  logic          proc_we = 1'b0;
  logic [DW-1:0] proc_rdata;
  logic          proc_done = 1'b0;

  always #10 clk = ~clk;

  cmd_mailbox dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_mem [DEPTH];
  int         m_ptr = 0;
  logic       m_flag = 1'b0;
  logic [7:0] m_rd = '0;

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int op = m_ptr;
    logic of = m_flag;
    logic [7:0] old_dat = m_mem[op];
    if (proc_we && !(host_wr && host_addr == 2'd1 && int'(proc_addr) == op))
      m_mem[proc_addr] = proc_wdata;
    if (host_wr) begin
      if (host_addr == 2'd0) m_ptr = int'(host_wdata) % DEPTH;
      else if (host_addr == 2'd1) begin
        m_mem[op] = host_wdata;
        m_ptr = (op + 1) % DEPTH;
      end
    end else if (host_rd) begin
      case (host_addr)
        2'd0: m_rd = 8'(op);
        2'd1: begin m_rd = old_dat; m_ptr = (op + 1) % DEPTH; end
        2'd2: m_rd = {7'd0, of};
        default: m_rd = 8'd0;
      endcase
    end
    if (host_wr && host_addr == 2'd2 && host_wdata[1]) m_flag = host_wdata[0];
    else if (proc_done) m_flag = 1'b0;
  endtask

  task automatic idle();
    host_wr = 1'b0; host_rd = 1'b0; proc_we = 1'b0; proc_done = 1'b0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag, "host_rdata", host_rdata, m_rd);
    cmp(tag, "proc_req", {7'd0, proc_req}, {7'd0, m_flag});
    cmp(tag, "proc_rdata", proc_rdata, m_mem[proc_addr]);
    idle();
  endtask

  task automatic hw(logic [1:0] a, logic [7:0] d, string tag);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    step(tag);
  endtask

  task automatic hr(logic [1:0] a, string tag);
    host_addr = a; host_rd = 1'b1;
    step(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] prev;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    cmp("R1", "host_rdata in reset", host_rdata, 8'd0);
    cmp("R1", "proc_req in reset", {7'd0, proc_req}, 8'd0);
    rst_n = 1'b1;
    step("R1");
    hr(2'd0, "R1");
    cmp("R1", "pointer after reset", host_rdata, 8'd0);

    // command frame
    hw(2'd0, 8'd0, "R2");
    for (int i = 0; i < 5; i++) hw(2'd1, 8'h10 + 8'(i), "R3");
    hr(2'd0, "R2");
    cmp("R2", "pointer after 5 writes", host_rdata, 8'd5);
    hw(2'd0, 8'hC3, "R2");
    hr(2'd0, "R2");
    cmp("R2", "pointer upper bits ignored", host_rdata, 8'd3);

    // flag gating
    hw(2'd2, 8'h01, "R6");
    hr(2'd2, "R6");
    cmp("R6", "flag without load enable", host_rdata, 8'd0);
    hw(2'd2, 8'h03, "R6");
    hr(2'd2, "R8");
    cmp("R8", "status word", host_rdata, 8'd1);
    hr(2'd0, "R8");
    cmp("R8", "pointer unmoved by status read", host_rdata, 8'd3);

    // processor side
    for (int i = 0; i < 5; i++) begin
      proc_addr = AW'(i);
      step("R9");
      cmp("R9", "processor reads command", proc_rdata, 8'h10 + 8'(i));
    end
    for (int i = 0; i < 6; i++) begin
      proc_addr = AW'(i); proc_wdata = 8'hA0 + 8'(i); proc_we = 1'b1;
      step("R9");
    end
    proc_done = 1'b1;
    step("R7");
    cmp("R7", "flag after done", {7'd0, proc_req}, 8'd0);

    // response readback
    hw(2'd0, 8'd0, "R4");
    for (int i = 0; i < 6; i++) begin
      hr(2'd1, "R4");
      cmp("R4", "response byte", host_rdata, 8'hA0 + 8'(i));
    end
    step("R4");
    cmp("R4", "rdata holds", host_rdata, 8'hA5);

    // wrap
    hw(2'd0, 8'd62, "R5");
    for (int i = 0; i < 4; i++) hw(2'd1, 8'h50 + 8'(i), "R5");
    hr(2'd0, "R5");
    cmp("R5", "pointer after wrap", host_rdata, 8'd2);
    hw(2'd0, 8'd63, "R5");
    hr(2'd1, "R5");
    cmp("R5", "byte at 63", host_rdata, 8'h51);
    hr(2'd1, "R5");
    cmp("R5", "byte at 0 after wrap", host_rdata, 8'h52);

    // same-byte collision
    hw(2'd0, 8'd8, "R9");
    host_addr = 2'd1; host_wdata = 8'h77; host_wr = 1'b1;
    proc_addr = AW'(8); proc_wdata = 8'h99; proc_we = 1'b1;
    step("R9");
    cmp("R9", "host wins collision", proc_rdata, 8'h77);

    // flag races
    hw(2'd2, 8'h03, "R6");
    host_addr = 2'd2; host_wdata = 8'h02; host_wr = 1'b1; proc_done = 1'b1;
    step("R7");
    cmp("R7", "clear plus done", {7'd0, proc_req}, 8'd0);
    host_addr = 2'd2; host_wdata = 8'h03; host_wr = 1'b1; proc_done = 1'b1;
    step("R7");
    cmp("R7", "set plus done", {7'd0, proc_req}, 8'd1);
    hw(2'd2, 8'h02, "R6");
    cmp("R6", "host clears stale flag", {7'd0, proc_req}, 8'd0);

    // write and read together, unused slot
    hw(2'd0, 8'd20, "R10");
    prev = host_rdata;
    host_addr = 2'd1; host_wdata = 8'h3C; host_wr = 1'b1; host_rd = 1'b1;
    step("R10");
    cmp("R10", "rdata untouched on wr+rd", host_rdata, prev);
    hr(2'd0, "R10");
    cmp("R10", "pointer after wr+rd", host_rdata, 8'd21);
    hw(2'd3, 8'hFF, "R10");
    hr(2'd3, "R10");
    cmp("R10", "unused slot reads 0", host_rdata, 8'd0);
    hr(2'd0, "R10");
    cmp("R10", "unused slot write ignored", host_rdata, 8'd21);

    // mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      host_addr  = 2'($urandom_range(0, 3));
      host_wdata = 8'($urandom_range(0, 255));
      host_wr    = ($urandom_range(0, 3) == 0);
      host_rd    = ($urandom_range(0, 2) == 0);
      proc_addr  = AW'($urandom_range(0, DEPTH - 1));
      proc_wdata = 8'($urandom_range(0, 255));
      proc_we    = ($urandom_range(0, 4) == 0);
      proc_done  = ($urandom_range(0, 6) == 0);
      step("R3");
    end

    summary();
    $finish;
  end
endmodule